// File: doc/BRIEF.md
# Strip Cluster Finder

This block compresses the binary hit map of one event from a row of silicon strips into a short list of cluster words. A load strobe captures a 256-bit map. The finder then searches the captured map from strip 0 upward. For every hit it finds, it emits one 12-bit word. The word holds the address of that hit strip, the states of the three strips above it, and a flag that marks the final word of the event. The seed strip and its three neighbours are then removed from the working copy, and the search goes on. In this way one word covers up to four strips.

Words leave on a valid/ready stream at a rate of up to one per clock. When the consumer holds ready low, the finder waits and keeps its current word. A one-cycle done pulse follows the acceptance of the final word. An event with no hits still yields one terminator word, so the consumer always sees an end of event.

Top module: `strip_cluster_engine`

## Requirements
- R1: A load_i pulse while the block is idle captures map_i. The first word then carries the address of the lowest-numbered hit strip, and each later word carries the lowest strip still present in the working map.
- R2: The word layout is as follows. Bits [11:4] hold the seed strip address. Bit 3 is the state of strip seed+1, bit 2 is the state of strip seed+2, and bit 1 is the state of strip seed+3. Bit 0 is the last-cluster flag.
- R3: After a word is accepted, the seed strip and its three upper neighbours are cleared, so the next seed address is at least 4 above the previous one.
- R4: A neighbour position above strip 255 reads as 0 in the pattern field.
- R5: The last-cluster flag is 1 only on the word after which no hit remains. An event produces exactly as many words as the clusters the search finds.
- R6: An event with no hits produces exactly one word, 0xFF1 (address 0xFF, pattern 000, flag 1).
- R7: While clu_valid_o is high and clu_ready_i is low, clu_valid_o stays high and clu_word_o stays unchanged. No word is lost or repeated.
- R8: done_o is high for exactly one cycle, in the cycle after the final word is accepted. clu_valid_o is low in that cycle.
- R9: A load_i pulse while words of an event are still pending is ignored. The pending sequence continues unchanged.
- R10: After reset, clu_valid_o and done_o are low, and no word is offered until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one word per cycle at most |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture strobe for map_i |
| map_i | input | 256 | Strip hit map of one event, bit n is strip n |
| clu_ready_i | input | 1 | Consumer accepts the offered word |
| clu_valid_o | output | 1 | A cluster word is offered |
| clu_word_o | output | 12 | Cluster word, layout per R2 |
| done_o | output | 1 | One-cycle pulse after the final word of an event |

## Verification
The assertions assume that map_i is held stable in any cycle in which load_i is high and the block is idle. They also assume that clu_ready_i is a clean level sampled at the clock edge. The bench changes inputs only on the falling edge, so both assumptions hold. Stall checks rely on the consumer being free to drop ready at any time. The bench drives ready from a pseudo-random sequence in one pass and holds it low for several cycles in a directed case. The bench pulses load only while the block is idle, except in the dedicated R9 case.

// File: rtl/scf_pkg.sv
package scf_pkg;
  typedef enum logic {SCF_IDLE = 1'b0, SCF_EMIT = 1'b1} scf_state_e;
endpackage

// File: rtl/scf_seed_pick.sv
module scf_seed_pick #(
  parameter int NSTRIPS = 256,
  localparam int AW = $clog2(NSTRIPS)
) (
  input  logic [NSTRIPS-1:0] map_i,
  output logic [AW-1:0]      seed_o,
  output logic               any_o
);
  function automatic logic [AW-1:0] lowest_set(input logic [NSTRIPS-1:0] m);
    logic [AW-1:0] r;
    r = '0;
    for (int i = NSTRIPS - 1; i >= 0; i--)
      if (m[i]) r = AW'(i);
    return r;
  endfunction

  assign seed_o = lowest_set(map_i);
  assign any_o  = |map_i;
endmodule

// File: rtl/scf_window.sv
module scf_window #(
  parameter int NSTRIPS = 256,
  parameter int NBR     = 3,
  localparam int AW = $clog2(NSTRIPS)
) (
  input  logic [NSTRIPS-1:0] map_i,
  input  logic [AW-1:0]      seed_i,
  output logic [NBR-1:0]     pattern_o,
  output logic [NSTRIPS-1:0] rest_o,
  output logic               rest_empty_o
);
  logic [NSTRIPS-1:0] clr_mask;

  always_comb begin
    pattern_o = '0;
    for (int k = 0; k < NBR; k++) begin
      logic [AW:0] idx;
      idx = {1'b0, seed_i} + (AW+1)'(k + 1);
      if (idx < (AW+1)'(NSTRIPS)) pattern_o[NBR-1-k] = map_i[idx[AW-1:0]];
    end
  end

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k <= NBR; k++) begin
      logic [AW:0] idx;
      idx = {1'b0, seed_i} + (AW+1)'(k);
      if (idx < (AW+1)'(NSTRIPS)) clr_mask[idx[AW-1:0]] = 1'b1;
    end
  end

  assign rest_o       = map_i & ~clr_mask;
  assign rest_empty_o = ~|rest_o;
endmodule

// File: rtl/strip_cluster_engine.sv
module strip_cluster_engine #(
  parameter int NSTRIPS = 256,
  parameter int NBR     = 3,
  localparam int AW = $clog2(NSTRIPS),
  localparam int WW = AW + NBR + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [NSTRIPS-1:0] map_i,
  input  logic               clu_ready_i,
  output logic               clu_valid_o,
  output logic [WW-1:0]      clu_word_o,
  output logic               done_o
);
  import scf_pkg::*;

  function automatic logic [WW-1:0] pack_word(input logic [AW-1:0] a,
                                              input logic [NBR-1:0] p,
                                              input logic l);
    return {a, p, l};
  endfunction

  scf_state_e         state;
  logic [NSTRIPS-1:0] work_map;
  logic [AW-1:0]      seed;
  logic               any_hit;
  logic [NBR-1:0]     pattern;
  logic [NSTRIPS-1:0] rest_map;
  logic               rest_empty;

  // named events for the assertions
  logic               fire;
  logic               last_flag;
  logic               take_load;

  scf_seed_pick #(.NSTRIPS(NSTRIPS)) u_pick (
    .map_i (work_map),
    .seed_o(seed),
    .any_o (any_hit)
  );

  scf_window #(.NSTRIPS(NSTRIPS), .NBR(NBR)) u_win (
    .map_i       (work_map),
    .seed_i      (seed),
    .pattern_o   (pattern),
    .rest_o      (rest_map),
    .rest_empty_o(rest_empty)
  );

  assign clu_valid_o = (state == SCF_EMIT);
  assign last_flag   = any_hit ? rest_empty : 1'b1;
  assign clu_word_o  = any_hit ? pack_word(seed, pattern, rest_empty)
                               : pack_word({AW{1'b1}}, '0, 1'b1);
  assign fire        = clu_valid_o && clu_ready_i;
  assign take_load   = (state == SCF_IDLE) && load_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SCF_IDLE;
      work_map <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take_load) begin
        work_map <= map_i;
        state    <= SCF_EMIT;
      end else if (fire) begin
        work_map <= rest_map;
        if (last_flag) begin
          state  <= SCF_IDLE;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R1: an offered non-empty word names a strip that is hit in the working map
  a_r1_seed_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (clu_valid_o && any_hit) |-> work_map[seed]);

  // R3: the next seed is at least four strips above the accepted one
  a_r3_address_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_flag) |=> (clu_valid_o &&
      ({1'b0, clu_word_o[WW-1 -: AW]} >= ({1'b0, $past(clu_word_o[WW-1 -: AW])} + (AW+1)'(NBR+1)))));

  // R5: nothing is offered after the final word is accepted
  a_r5_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clu_word_o[0]) |=> !clu_valid_o);

  // R7: a stalled word is held unchanged
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clu_valid_o && !clu_ready_i) |=> (clu_valid_o && $stable(clu_word_o)));

  // R8: done follows the final acceptance
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clu_word_o[0]) |=> done_o);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a load during an event leaves the working map alone
  a_r9_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (clu_valid_o && load_i && !fire) |=> $stable(work_map));
endmodule

// File: tb/sim_strip_cluster_engine.sv
module sim_strip_cluster_engine;
  localparam int CLK_PERIOD = 26;
  localparam int N  = 256;
  localparam int NV = 8;

  // stimulus maps, expected word count, expected first word
  localparam logic [N-1:0] MAPS [NV] = '{
    256'h0,                                            // R6 empty
    256'h1,                                            // R1 strip 0 only
    (256'h1 << 255),                                   // R4 top strip only
    (256'h7 << 253),                                   // R4 cut-off neighbours
    {256{1'b1}},                                       // R3 dense
    256'h17,                                           // R3 strip 4 survives
    {64{4'h5}},                                        // R2 alternating
    (256'h1 << 7) | (256'h1 << 100) | (256'h1 << 200)  // R1 sparse
  };
  localparam int NCL [NV] = '{1, 1, 1, 1, 64, 2, 64, 3};
  localparam logic [11:0] FIRST [NV] = '{12'hFF1, 12'h001, 12'hFF1, 12'hFDD,
                                         12'h00E, 12'h00C, 12'h004, 12'h070};

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, ready = 1'b0;
  logic [N-1:0] map = '0;
  logic valid, done;
  logic [11:0] word;

  int checks = 0, fails = 0;
  logic [11:0] exp_w [64];
  int exp_n;
  logic [15:0] lfsr = 16'hACE1;

  strip_cluster_engine u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load), .map_i(map),
    .clu_ready_i(ready), .clu_valid_o(valid), .clu_word_o(word), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
    end
  endtask

  // independent model: walk strips, skip four after every hit
  task automatic build_ref(input logic [N-1:0] m);
    int i;
    exp_n = 0;
    i = 0;
    while (i < N) begin
      if (m[i]) begin
        logic [2:0] p;
        p[2] = (i + 1 < N) ? m[i+1] : 1'b0;
        p[1] = (i + 2 < N) ? m[i+2] : 1'b0;
        p[0] = (i + 3 < N) ? m[i+3] : 1'b0;
        exp_w[exp_n] = {8'(i), p, 1'b0};
        exp_n++;
        i += 4;
      end else i++;
    end
    if (exp_n == 0) begin
      exp_w[0] = 12'hFF1;
      exp_n = 1;
    end else exp_w[exp_n-1][0] = 1'b1;
  endtask

  task automatic run_event(input logic [N-1:0] m, input bit stall, input bit inject,
                           input int ncl, input logic [11:0] first, input string tag);
    int got, cyc;
    bit finished;
    build_ref(m);
    @(negedge clk);
    map = m; load = 1'b1;
    @(negedge clk);
    load = 1'b0; map = '0;
    got = 0; cyc = 0; finished = 0;
    while (!finished && cyc < 3000) begin
      ready = stall ? lfsr[0] : 1'b1;
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (inject && cyc == 2) begin load = 1'b1; map = ~m; end
      else begin load = 1'b0; map = '0; end
      if (valid && ready) begin
        if (got == 0)
          check(word == first, "R2", {tag, " first word"}, 32'(word), 32'(first));
        if (got < 64)
          check(word == exp_w[got], "R1/R3/R5", {tag, " word"}, 32'(word), 32'(exp_w[got]));
        got++;
        if (word[0]) finished = 1;
      end
      @(negedge clk);
      cyc++;
    end
    load = 1'b0; map = '0; ready = 1'b0;
    check(got == ncl, "R5", {tag, " word count"}, 32'(got), 32'(ncl));
    check(done && !valid, "R8", {tag, " done after last"}, {30'b0, done, valid}, 32'h2);
    @(negedge clk);
    check(!done, "R8", {tag, " done one cycle"}, 32'(done), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!valid && !done, "R10", "reset outputs", {30'b0, valid, done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!valid, "R10", "idle after reset", 32'(valid), 32'h0);

    // table walk, free-running then randomly stalled consumer
    for (int mode = 0; mode < 2; mode++)
      for (int e = 0; e < NV; e++)
        run_event(MAPS[e], mode[0], 1'b0, NCL[e], FIRST[e], $sformatf("vec%0d/m%0d", e, mode));

    // R7 directed stall: hold ready low, word must stay put
    begin
      logic [11:0] held;
      @(negedge clk);
      map = (256'h1 << 7) | (256'h1 << 100); load = 1'b1;
      @(negedge clk);
      load = 1'b0; map = '0; ready = 1'b0;
      held = word;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(valid && word == held, "R7", "stalled word", 32'(word), 32'(held));
      end
      check(held == 12'h070, "R7", "stalled word value", 32'(held), 32'h070);
      ready = 1'b1;
      @(negedge clk);
      check(valid && word == 12'h641, "R7", "next after stall", 32'(word), 32'h641);
      @(negedge clk);
      ready = 1'b0;
      check(done && !valid, "R8", "done after stall event", {30'b0, done, valid}, 32'h2);
    end

    // R9 load during an event is ignored
    run_event(256'h1 | (256'h1 << 40) | (256'h1 << 80) | (256'h1 << 120), 1'b0, 1'b1,
              4, 12'h000, "R9 inject");

    // R10 reset in the middle of an event
    @(negedge clk);
    map = {256{1'b1}}; load = 1'b1;
    @(negedge clk);
    load = 1'b0; map = '0;
    check(valid, "R10", "busy before reset", 32'(valid), 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(!valid && !done, "R10", "reset clears event", {30'b0, valid, done}, 32'h0);
    @(negedge clk);
    check(!valid, "R10", "stays idle", 32'(valid), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule